// File: doc/BRIEF.md
# Cassette Transport Control Sequencer

This block is the digital controller of a cassette deck transport. It accepts single-cycle, active-high button pulses for play in either tape direction, fast wind in either direction, stop and record, plus two record-protect contact levels (one per direction), a cassette-missing / beam-broken level, tape-motion pulses from the counter sensor and a 1 kHz reference tick. From these it drives the capstan and reel motor commands, the direction relay, the audio mute, the record enable, the erase/bias oscillator enable and the front-panel LEDs.

The outputs that touch the tape or the audio path are sequenced in time. Entering play does not release the mute or start the erase oscillator at once. Both wait a programmable number of reference ticks, so that switching noise cannot reach the output and the tape cannot be erased by accident. The direction relay follows a reverse play command only after a longer wait. When the cassette is pulled or the light beam is broken, the transport stops and the stop LED flashes. A play direction that was active at that moment is remembered and taken up again once a cassette is back. A motion watchdog stops the transport if the counter sensor stays silent for too long while tape should be moving.

Top module: `tape_transport_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to stop. After `rst_n` rises, with no input active, the motor outputs, `rec_en`, `osc_en` and `dir_relay` are 0, `mute` is 1, `led_stop` is steadily 1 and both play LEDs are 0. All button and contact inputs are active high.
- R2: A `btn_record` pulse sets `rec_en` only while the transport is in play. In forward play `wp_fwd` must be 0. In reverse play `wp_rev` must be 0. A high contact for the running direction makes the pulse have no effect, and the contact of the other direction does not matter.
- R3: `rec_en` is 0 outside play. Any stop, play, fast-forward or rewind pulse clears it, and so does a stop forced by R8 or R10. A record pulse that arrives together with a transport button is ignored.
- R4: `mute` is 1 in stop, fast forward and rewind. It is also 1 in any cycle in which `cass_absent` is 1, with no register delay.
- R5: On entering play, or on a change of play direction, `mute` stays 1. It goes to 0 only once `MUTE_TICKS` reference ticks have been counted from the cycle after the play state was taken.
- R6: `osc_en` is 0 outside play. In play it becomes 1 after `OSC_TICKS` reference ticks, counted the same way as in R5.
- R7: `dir_relay` becomes 1 after `REL_TICKS` reference ticks of reverse play. It drops to 0 in the cycle the transport leaves reverse play.
- R8: When `cass_absent` is 1 at a clock edge, the transport goes to stop on that edge with all motor outputs and `rec_en` at 0. While stopped after this, `led_stop` alternates every `BLINK_HALF` reference ticks instead of staying on.
- R9: If R8 ends play, that direction's LED stays lit while no cassette is present. At the first edge with `cass_absent` at 0, play resumes in that direction, with the delays of R5 to R7 restarting.
- R10: While any motor runs, `WATCH_TICKS` reference ticks with no `motion_pulse` force stop on the next edge. A motion pulse restarts the count.
- R11: When several transport buttons pulse in the same cycle, stop wins over forward play, forward play over reverse play, reverse play over fast forward, and fast forward over rewind.
- R12: A stop pulse, given while the cassette is missing or in the cycle it returns, discards the remembered play direction. No play resumes and the direction LED goes dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1k | input | 1 | One-cycle reference tick, nominally 1 kHz |
| btn_play_fwd | input | 1 | Play forward pulse |
| btn_play_rev | input | 1 | Play reverse pulse |
| btn_ffwd | input | 1 | Fast-forward pulse |
| btn_rewind | input | 1 | Rewind pulse |
| btn_stop | input | 1 | Stop pulse |
| btn_record | input | 1 | Record pulse |
| wp_fwd | input | 1 | Record protect for the forward side, 1 = protected |
| wp_rev | input | 1 | Record protect for the reverse side, 1 = protected |
| cass_absent | input | 1 | 1 = cassette missing or beam interrupted |
| motion_pulse | input | 1 | Tape-motion pulse from the counter sensor |
| capstan_on | output | 1 | Play drive motor command |
| reel_ffwd | output | 1 | Fast-forward reel command |
| reel_rewind | output | 1 | Rewind reel command |
| dir_relay | output | 1 | Direction relay drive, 1 = reverse side |
| mute | output | 1 | Audio mute, 1 = muted |
| rec_en | output | 1 | Record enable |
| osc_en | output | 1 | Erase/bias oscillator enable |
| led_play_fwd | output | 1 | Forward play LED |
| led_play_rev | output | 1 | Reverse play LED |
| led_stop | output | 1 | Stop LED, flashes after cassette loss |
| led_record | output | 1 | Record LED |

## Verification
Several rules are checked on every cycle. At most one motor command is active at a time. Record needs play, and a record start needs a record pulse with the forward protect contact low when playing forward. The mute follows a missing cassette at once, and play is never entered with the mute already released. The oscillator is off outside play, the relay is on only in reverse play, and a missing cassette stops the motors on the next edge. The exact tick counts behind the mute, oscillator and relay delays cannot be seen by these rules. Neither can the watchdog window, the blink period, resume in the stored direction, the button priority or the clearing of the stored direction by stop. The bench's scenarios and its cycle-by-cycle reference model show those.

// File: rtl/tt_pkg.sv
// Shared types of the cassette transport controller.
// Assumes: a single clock domain; all encodings are internal only.
package tt_pkg;

    typedef enum logic [2:0] {
        MODE_STOP   = 3'd0,
        MODE_PLAY_F = 3'd1,
        MODE_PLAY_R = 3'd2,
        MODE_FFWD   = 3'd3,
        MODE_REWIND = 3'd4
    } mode_t;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_FWD  = 2'd1,
        DIR_REV  = 2'd2
    } dir_t;

endpackage

// File: rtl/tt_tick_delay.sv
// Counts reference ticks while not cleared and reports when N ticks have
// been seen. Assumes tick is a one-cycle pulse; the count saturates at N.
module tt_tick_delay #(
    parameter int N = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(N + 1);
    localparam logic [W-1:0] LIM = W'(N);

    logic [W-1:0] cnt;

    // Tick counter: cleared on request, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIM);
endmodule

// File: rtl/tt_motion_watch.sv
// Tape-motion watchdog: counts reference ticks since the last motion pulse
// while the transport moves; flags a fault when the window is used up.
// Assumes motion_pulse and tick are synchronous one-cycle pulses.
module tt_motion_watch #(
    parameter int WINDOW = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic moving,
    input  logic motion_pulse,
    input  logic tick,
    output logic fault
);
    localparam int W = $clog2(WINDOW + 1);
    localparam logic [W-1:0] LIM = W'(WINDOW);

    logic [W-1:0] silent;

    // Silence counter: reset by motion or by standing still.
    always_ff @(posedge clk) begin
        if (!rst_n || !moving || motion_pulse) begin
            silent <= '0;
        end else if (tick && silent != LIM) begin
            silent <= silent + 1'b1;
        end
    end

    assign fault = moving && (silent == LIM);
endmodule

// File: rtl/tt_blink.sv
// Free-running flash phase for the stop LED: toggles every HALF ticks.
// Assumes tick is a one-cycle pulse.
module tt_blink #(
    parameter int HALF = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic phase
);
    localparam int W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt;

    // Divider and phase flip-flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (tick) begin
            if (cnt == LAST) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tt_mode_fsm.sv
// Transport mode state machine: cassette loss, resume, watchdog stop,
// button priority and record arming. Assumes button inputs are one-cycle
// pulses and that cass_absent is already debounced.
module tt_mode_fsm
    import tt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cass_absent,
    input  logic  fault,
    input  logic  btn_play_fwd,
    input  logic  btn_play_rev,
    input  logic  btn_ffwd,
    input  logic  btn_rewind,
    input  logic  btn_stop,
    input  logic  btn_record,
    input  logic  wp_fwd,
    input  logic  wp_rev,
    output mode_t mode,
    output dir_t  held,
    output logic  rec,
    output logic  absent_r,
    output logic  play_start
);
    mode_t n_mode;
    dir_t  n_held;
    logic  n_rec;
    logic  any_btn;
    logic  rec_ok;

    assign any_btn = btn_stop | btn_play_fwd | btn_play_rev | btn_ffwd | btn_rewind;
    assign rec_ok  = btn_record &&
                     ((mode == MODE_PLAY_F && !wp_fwd) ||
                      (mode == MODE_PLAY_R && !wp_rev));

    // Next-state selection in fixed priority order.
    always_comb begin
        n_mode = mode;
        n_held = held;
        n_rec  = rec;
        if (cass_absent) begin
            n_mode = MODE_STOP;
            n_rec  = 1'b0;
            if (btn_stop)                 n_held = DIR_NONE;
            else if (mode == MODE_PLAY_F) n_held = DIR_FWD;
            else if (mode == MODE_PLAY_R) n_held = DIR_REV;
        end else if (held != DIR_NONE) begin
            n_held = DIR_NONE;
            n_rec  = 1'b0;
            if (btn_stop)            n_mode = MODE_STOP;
            else if (held == DIR_FWD) n_mode = MODE_PLAY_F;
            else                      n_mode = MODE_PLAY_R;
        end else if (fault) begin
            n_mode = MODE_STOP;
            n_rec  = 1'b0;
        end else if (any_btn) begin
            n_rec = 1'b0;
            if (btn_stop)          n_mode = MODE_STOP;
            else if (btn_play_fwd) n_mode = MODE_PLAY_F;
            else if (btn_play_rev) n_mode = MODE_PLAY_R;
            else if (btn_ffwd)     n_mode = MODE_FFWD;
            else                   n_mode = MODE_REWIND;
        end else if (rec_ok) begin
            n_rec = 1'b1;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MODE_STOP;
            held       <= DIR_NONE;
            rec        <= 1'b0;
            absent_r   <= 1'b0;
            play_start <= 1'b0;
        end else begin
            mode       <= n_mode;
            held       <= n_held;
            rec        <= n_rec;
            absent_r   <= cass_absent;
            play_start <= (n_mode == MODE_PLAY_F || n_mode == MODE_PLAY_R) &&
                          (n_mode != mode);
        end
    end
endmodule

// File: rtl/tape_transport_ctrl.sv
// Top of the cassette transport controller. Combines the mode machine,
// three tick delays (mute release, oscillator enable, direction relay),
// the motion watchdog and the stop LED flasher. Assumes tick_1k is a
// one-cycle pulse at the reference rate and all inputs are synchronous.
module tape_transport_ctrl
    import tt_pkg::*;
#(
    parameter int MUTE_TICKS  = 100,
    parameter int OSC_TICKS   = 100,
    parameter int REL_TICKS   = 200,
    parameter int WATCH_TICKS = 500,
    parameter int BLINK_HALF  = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1k,
    input  logic btn_play_fwd,
    input  logic btn_play_rev,
    input  logic btn_ffwd,
    input  logic btn_rewind,
    input  logic btn_stop,
    input  logic btn_record,
    input  logic wp_fwd,
    input  logic wp_rev,
    input  logic cass_absent,
    input  logic motion_pulse,
    output logic capstan_on,
    output logic reel_ffwd,
    output logic reel_rewind,
    output logic dir_relay,
    output logic mute,
    output logic rec_en,
    output logic osc_en,
    output logic led_play_fwd,
    output logic led_play_rev,
    output logic led_stop,
    output logic led_record
);
    localparam int NDLY = 3;
    localparam int DLY_MUTE = 0;
    localparam int DLY_OSC  = 1;
    localparam int DLY_REL  = 2;
    localparam int DLY_TICKS [NDLY] = '{MUTE_TICKS, OSC_TICKS, REL_TICKS};

    mode_t mode;
    dir_t  held;
    logic  rec, absent_r, play_start, fault, blink_ph;
    logic  is_play, is_rev;
    logic  [NDLY-1:0] dly_clr, dly_done;

    tt_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cass_absent  (cass_absent),
        .fault        (fault),
        .btn_play_fwd (btn_play_fwd),
        .btn_play_rev (btn_play_rev),
        .btn_ffwd     (btn_ffwd),
        .btn_rewind   (btn_rewind),
        .btn_stop     (btn_stop),
        .btn_record   (btn_record),
        .wp_fwd       (wp_fwd),
        .wp_rev       (wp_rev),
        .mode         (mode),
        .held         (held),
        .rec          (rec),
        .absent_r     (absent_r),
        .play_start   (play_start)
    );

    assign is_play = (mode == MODE_PLAY_F) || (mode == MODE_PLAY_R);
    assign is_rev  = (mode == MODE_PLAY_R);

    // Clear conditions: each delay restarts on every new play state.
    assign dly_clr[DLY_MUTE] = !is_play || play_start;
    assign dly_clr[DLY_OSC]  = !is_play || play_start;
    assign dly_clr[DLY_REL]  = !is_rev  || play_start;

    for (genvar g = 0; g < NDLY; g++) begin : g_dly
        tt_tick_delay #(.N(DLY_TICKS[g])) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (dly_clr[g]),
            .tick  (tick_1k),
            .done  (dly_done[g])
        );
    end

    tt_motion_watch #(.WINDOW(WATCH_TICKS)) u_watch (
        .clk          (clk),
        .rst_n        (rst_n),
        .moving       (mode != MODE_STOP),
        .motion_pulse (motion_pulse),
        .tick         (tick_1k),
        .fault        (fault)
    );

    tt_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1k),
        .phase (blink_ph)
    );

    // Output decode; delayed outputs are gated by the state they belong to.
    assign capstan_on   = is_play;
    assign reel_ffwd    = (mode == MODE_FFWD);
    assign reel_rewind  = (mode == MODE_REWIND);
    assign mute         = cass_absent || !(is_play && !play_start && dly_done[DLY_MUTE]);
    assign osc_en       = is_play && !play_start && dly_done[DLY_OSC];
    assign dir_relay    = is_rev && !play_start && dly_done[DLY_REL];
    assign rec_en       = rec;
    assign led_record   = rec;
    assign led_play_fwd = (mode == MODE_PLAY_F) || (held == DIR_FWD);
    assign led_play_rev = (mode == MODE_PLAY_R) || (held == DIR_REV);
    assign led_stop     = (mode == MODE_STOP) && (absent_r ? blink_ph : 1'b1);
endmodule

// File: rtl/tt_checker.sv
// Property checker for tape_transport_ctrl, attached by bind below.
// Assumes it sees only the top-level ports.
module tt_checker (
    input logic clk,
    input logic rst_n,
    input logic cass_absent,
    input logic btn_record,
    input logic wp_fwd,
    input logic capstan_on,
    input logic reel_ffwd,
    input logic reel_rewind,
    input logic dir_relay,
    input logic mute,
    input logic rec_en,
    input logic osc_en,
    input logic led_play_fwd,
    input logic led_play_rev
);
    p_one_motor_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({capstan_on, reel_ffwd, reel_rewind}));

    p_rec_in_play_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |-> capstan_on);

    p_rec_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_en) |-> $past(btn_record));

    p_rec_protect_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rec_en) && led_play_fwd) |-> !$past(wp_fwd));

    p_absent_mutes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cass_absent |-> mute);

    p_play_enters_muted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capstan_on) |-> mute);

    p_osc_only_play_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capstan_on |-> !osc_en);

    p_relay_only_rev_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dir_relay |-> (capstan_on && led_play_rev));

    p_absent_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cass_absent |=> (!capstan_on && !reel_ffwd && !reel_rewind && !rec_en));
endmodule

bind tape_transport_ctrl tt_checker u_tt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cass_absent  (cass_absent),
    .btn_record   (btn_record),
    .wp_fwd       (wp_fwd),
    .capstan_on   (capstan_on),
    .reel_ffwd    (reel_ffwd),
    .reel_rewind  (reel_rewind),
    .dir_relay    (dir_relay),
    .mute         (mute),
    .rec_en       (rec_en),
    .osc_en       (osc_en),
    .led_play_fwd (led_play_fwd),
    .led_play_rev (led_play_rev)
);

// File: tb/tb_tape_transport_ctrl.sv
// Bench: behavioural reference model compared on every clock plus
// directed scenarios for each requirement.
module tb_tape_transport_ctrl;
    localparam int MUTE = 4, OSC = 6, REL = 8, WIN = 12, HALF = 3, TDIV = 5;

    logic clk = 1'b0, rst_n = 1'b0, tick_1k = 1'b0;
    logic btn_play_fwd = 0, btn_play_rev = 0, btn_ffwd = 0, btn_rewind = 0;
    logic btn_stop = 0, btn_record = 0, wp_fwd = 0, wp_rev = 0;
    logic cass_absent = 0, motion_pulse = 0;
    logic capstan_on, reel_ffwd, reel_rewind, dir_relay, mute, rec_en, osc_en;
    logic led_play_fwd, led_play_rev, led_stop, led_record;

    int total = 0, bad = 0, tdiv_cnt = 0;
    bit feed = 1, finished = 0, saw0 = 0, saw1 = 0;

    always #5 clk = ~clk;

    tape_transport_ctrl #(.MUTE_TICKS(MUTE), .OSC_TICKS(OSC), .REL_TICKS(REL),
                          .WATCH_TICKS(WIN), .BLINK_HALF(HALF)) dut (.*);

    // Reference model state: mode 0 stop,1 play fwd,2 play rev,3 ffwd,4 rewind.
    int m_mode = 0, m_held = 0, m_rec = 0, m_absr = 0, m_pst = 0;
    int m_mc = 0, m_oc = 0, m_rc = 0, m_wc = 0, m_bc = 0, m_ph = 0;
    int nm, nh, nr;
    bit flt, mplay;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_held = 0; m_rec = 0; m_absr = 0; m_pst = 0;
            m_mc = 0; m_oc = 0; m_rc = 0; m_wc = 0; m_bc = 0; m_ph = 0;
        end else begin
            nm = m_mode; nh = m_held; nr = m_rec;
            flt = (m_mode != 0) && (m_wc == WIN);
            mplay = (m_mode == 1) || (m_mode == 2);
            if (cass_absent) begin
                nm = 0; nr = 0;
                if (btn_stop) nh = 0;
                else if (m_mode == 1 || m_mode == 2) nh = m_mode;
            end else if (m_held != 0) begin
                nm = btn_stop ? 0 : m_held; nh = 0; nr = 0;
            end else if (flt) begin
                nm = 0; nr = 0;
            end else if (btn_stop) begin nm = 0; nr = 0;
            end else if (btn_play_fwd) begin nm = 1; nr = 0;
            end else if (btn_play_rev) begin nm = 2; nr = 0;
            end else if (btn_ffwd) begin nm = 3; nr = 0;
            end else if (btn_rewind) begin nm = 4; nr = 0;
            end else if (btn_record && ((m_mode == 1 && !wp_fwd) || (m_mode == 2 && !wp_rev)))
                nr = 1;
            if (!mplay || m_pst != 0) begin m_mc = 0; m_oc = 0; end
            else if (tick_1k) begin
                if (m_mc < MUTE) m_mc++;
                if (m_oc < OSC) m_oc++;
            end
            if (m_mode != 2 || m_pst != 0) m_rc = 0;
            else if (tick_1k && m_rc < REL) m_rc++;
            if (m_mode == 0 || motion_pulse) m_wc = 0;
            else if (tick_1k && m_wc < WIN) m_wc++;
            if (tick_1k) begin
                if (m_bc == HALF - 1) begin m_bc = 0; m_ph = 1 - m_ph; end
                else m_bc++;
            end
            m_pst = ((nm == 1 || nm == 2) && nm != m_mode) ? 1 : 0;
            m_absr = cass_absent;
            m_mode = nm; m_held = nh; m_rec = nr;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp1(input string req, input logic act, input bit exp);
        chk(act === exp, req, int'(act), int'(exp));
    endtask

    // Compare every output with the model.
    task automatic compare_all();
        bit pl;
        pl = (m_mode == 1 || m_mode == 2);
        cmp1("R11 capstan_on", capstan_on, pl);
        cmp1("R11 reel_ffwd", reel_ffwd, m_mode == 3);
        cmp1("R11 reel_rewind", reel_rewind, m_mode == 4);
        cmp1("R4/R5 mute", mute, cass_absent || !(pl && m_mc == MUTE && m_pst == 0));
        cmp1("R6 osc_en", osc_en, pl && m_oc == OSC && m_pst == 0);
        cmp1("R7 dir_relay", dir_relay, m_mode == 2 && m_rc == REL && m_pst == 0);
        cmp1("R2/R3 rec_en", rec_en, m_rec != 0);
        cmp1("R3 led_record", led_record, m_rec != 0);
        cmp1("R9 led_play_fwd", led_play_fwd, m_mode == 1 || m_held == 1);
        cmp1("R9 led_play_rev", led_play_rev, m_mode == 2 || m_held == 2);
        cmp1("R8 led_stop", led_stop, m_mode == 0 && (m_absr != 0 ? m_ph != 0 : 1'b1));
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) compare_all();
            if (led_stop === 1'b0) saw0 = 1;
            if (led_stop === 1'b1) saw1 = 1;
            btn_play_fwd = 0; btn_play_rev = 0; btn_ffwd = 0;
            btn_rewind = 0; btn_stop = 0; btn_record = 0;
            tdiv_cnt = (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
            tick_1k = (tdiv_cnt == TDIV - 1);
            motion_pulse = feed && tick_1k;
        end
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(2);
        // R1: reset state
        cmp1("R1 mute", mute, 1); cmp1("R1 led_stop", led_stop, 1);
        cmp1("R1 capstan", capstan_on, 0); cmp1("R1 osc", osc_en, 0);
        cmp1("R1 relay", dir_relay, 0); cmp1("R1 rec", rec_en, 0);
        // R2: record ignored in stop
        btn_record = 1; step(2);
        cmp1("R2 record in stop", rec_en, 0);
        // R5: play forward, mute stays on
        btn_play_fwd = 1; step(2);
        cmp1("R5 mute at play start", mute, 1);
        cmp1("R6 osc at play start", osc_en, 0);
        step(30);
        cmp1("R5 mute released", mute, 0);
        step(10);
        cmp1("R6 osc enabled", osc_en, 1);
        // R2: protected forward side ignores record; other side irrelevant
        wp_fwd = 1; btn_record = 1; step(2);
        cmp1("R2 protected fwd", rec_en, 0);
        wp_fwd = 0; wp_rev = 1; btn_record = 1; step(2);
        cmp1("R2 record fwd", rec_en, 1);
        // R3: record with a transport button is ignored, ffwd cancels record
        btn_ffwd = 1; btn_record = 1; step(2);
        cmp1("R3 ffwd clears rec", rec_en, 0);
        cmp1("R4 mute in ffwd", mute, 1);
        cmp1("R6 osc off in ffwd", osc_en, 0);
        // R11: stop beats play, play fwd beats rewind
        btn_stop = 1; btn_play_fwd = 1; step(2);
        cmp1("R11 stop wins", led_stop, 1);
        btn_rewind = 1; btn_play_fwd = 1; step(2);
        cmp1("R11 play fwd wins", capstan_on, 1);
        cmp1("R11 no rewind", reel_rewind, 0);
        // R7: reverse play, relay delayed
        btn_play_rev = 1; step(20);
        cmp1("R7 relay not yet", dir_relay, 0);
        step(30);
        cmp1("R7 relay on", dir_relay, 1);
        btn_record = 1; step(2);
        cmp1("R2 rev protected", rec_en, 0);
        wp_rev = 0; btn_record = 1; step(2);
        cmp1("R2 record rev", rec_en, 1);
        // R8/R9: cassette removed during reverse play
        cass_absent = 1; step(1);
        cmp1("R4 mute immediate", mute, 1);
        step(1);
        cmp1("R8 motors off", capstan_on, 0);
        cmp1("R8 rec cancelled", rec_en, 0);
        cmp1("R9 rev LED held", led_play_rev, 1);
        cmp1("R7 relay dropped", dir_relay, 0);
        saw0 = 0; saw1 = 0; step(40);
        chk(saw0 && saw1, "R8 stop LED flashes", int'(saw0) + int'(saw1), 2);
        cass_absent = 0; step(2);
        cmp1("R9 resumes reverse", led_play_rev && capstan_on, 1);
        cmp1("R9 resume muted", mute, 1);
        // R12: stop while missing clears stored direction
        btn_play_fwd = 1; step(10);
        cass_absent = 1; step(3);
        cmp1("R9 fwd LED held", led_play_fwd, 1);
        btn_stop = 1; step(2);
        cmp1("R12 stored dir cleared", led_play_fwd, 0);
        cass_absent = 0; step(5);
        cmp1("R12 no resume", capstan_on, 0);
        // R10: motion watchdog
        btn_play_fwd = 1; step(2);
        feed = 0; step(30);
        cmp1("R10 still playing", capstan_on, 1);
        step(50);
        cmp1("R10 watchdog stop", capstan_on, 0);
        feed = 1; btn_rewind = 1; step(80);
        cmp1("R10 fed rewind keeps running", reel_rewind, 1);
        // R1: reset mid-run
        rst_n = 0; step(2); rst_n = 1; step(2);
        cmp1("R1 reset stops", reel_rewind, 0);
        cmp1("R1 reset mute", mute, 1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule